// File: doc/BRIEF.md
# Synchronized Multi-Channel PWM Timer

This block holds a group of up-counting timer channels (three by default, 16 bits wide) that can be tied together so their counters preset and clear as one. Each channel owns a counter, two general registers (A and B), a control register and a PWM output. A small register interface (address, write data, write strobe, combinational read data) reaches every counter, general register and control field, plus two shared registers: a sync-membership mask and a start mask.

A channel clears its counter on one of four sources: never, an A event, a B event, or a synchronous clear that follows whichever member of the sync group clears from its own source. An A or B event is a compare match, or an input capture when that register is put in capture mode. A typical use makes channel 0 the period master (clear on B match) and sets the other members to synchronous clear. Every member then counts the same period, and each PWM output rises on its A match and falls on its B match. The result is an aligned multi-phase PWM waveform. Counting is gated by one shared clock enable, `cnt_en`.

Top module: `sync_pwm_timer`

## Requirements
- R1: After reset every counter reads 0x0000, every general register reads 0xFFFF, every control register, the sync mask and the start mask read 0, and every PWM output is 0.
- R2: A channel's counter increments by one on each clock where `cnt_en` is 1 and its start bit (bit i of the start register at address NCH*4+1) is 1. It holds otherwise, and wraps from 0xFFFF to 0x0000.
- R3: A bus write to the counter of a channel whose sync bit (bit i of the sync register at address NCH*4) is 1 loads the same value into the counters of all channels with sync bit 1 in the same cycle. Channels with sync bit 0 are not loaded.
- R4: With clear-select 01 (or 10), a compare match of the counter with general register A (or B) on a counting clock loads 0 instead of the increment, so the period is G+1 counts.
- R5: With capture mode on for A (control bit 2) or B (control bit 3), a capture pulse on a counting clock copies the counter into that register. If the clear-select names that register, the pulse also clears the counter. A pulse on a non-counting clock does nothing.
- R6: A channel with clear-select 11 and sync bit 1 clears on a counting clock whenever any sync member clears from its own 01/10 source. With sync bit 0 it never clears and ignores writes to other counters.
- R7: A bus write to a counter takes priority over a clear and over the increment in the same cycle.
- R8: With PWM enable (control bit 4) set, the output goes to 1 on an A compare match and to 0 on a B compare match, and to 0 if both match together. With PWM enable clear, the output is 0.
- R9: With clear-select 00 the counter never clears, whatever the compare results.
- R10: Register map: address 4*i+0/1/2/3 is counter, general A, general B and control of channel i. The control field is bits [1:0] clear-select, [2] A capture, [3] B capture, [4] PWM enable. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Shared count enable (counting clock qualifier) |
| bus_addr | input | AW | Register address |
| bus_wdata | input | CW | Register write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | CW | Read data for `bus_addr` (combinational) |
| cap_in | input | NCH | Per-channel capture pulse, synchronous |
| pwm_out | output | NCH | Per-channel PWM output |

## Verification
The properties assume that the capture inputs and the bus are synchronous to `clk` and that a counter may change only through a bus write, an increment or a clear. The step and hold properties are therefore gated on the write strobe being low. The stimulus drives every input on the falling edge and raises `bus_we` only for single-cycle writes, with counting paused while configuration changes. The only exception is the deliberate same-cycle write used for the priority case. The sweeps run periods 0 to 7 and several sync-group shapes, and the expected counts are computed as modulo arithmetic on the number of counting clocks.

// File: rtl/sptmr_pkg.sv
package sptmr_pkg;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_A    = 2'b01,
        CLR_B    = 2'b10,
        CLR_SYNC = 2'b11
    } clr_sel_e;

    typedef struct packed {
        logic     pwm_en;
        logic     cap_b;
        logic     cap_a;
        clr_sel_e sel;
    } ch_ctrl_t;

    localparam int CTRL_W = $bits(ch_ctrl_t);

endpackage

// File: rtl/sptmr_chan.sv
module sptmr_chan
    import sptmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cnt_load,
    input  logic          gra_wr,
    input  logic          grb_wr,
    input  logic          ctrl_wr,
    input  logic [CW-1:0] wdata,
    input  logic          cap,
    input  logic          sync_member,
    input  logic          sync_clr,
    output logic          src_clr,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] gra,
    output logic [CW-1:0] grb,
    output ch_ctrl_t      ctrl,
    output logic          pwm
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] gra;
        logic [CW-1:0] grb;
        ch_ctrl_t      ctrl;
        logic          pwm;
    } chan_st_t;

    chan_st_t s_q, s_d;
    logic     hit_a, hit_b, ev_a, ev_b, own_clr, clr;

    always_comb begin
        // compare matches exist only for registers in compare mode
        hit_a = tick && !s_q.ctrl.cap_a && (s_q.cnt == s_q.gra);
        hit_b = tick && !s_q.ctrl.cap_b && (s_q.cnt == s_q.grb);
        ev_a  = s_q.ctrl.cap_a ? (tick && cap) : hit_a;
        ev_b  = s_q.ctrl.cap_b ? (tick && cap) : hit_b;

        unique case (s_q.ctrl.sel)
            CLR_A:   own_clr = ev_a;
            CLR_B:   own_clr = ev_b;
            default: own_clr = 1'b0;
        endcase
        clr = own_clr || ((s_q.ctrl.sel == CLR_SYNC) && sync_member && sync_clr);

        s_d = s_q;

        // counter: bus load > clear > increment
        if (cnt_load) begin
            s_d.cnt = wdata;
        end else if (tick) begin
            s_d.cnt = clr ? '0 : s_q.cnt + CW'(1);
        end

        if (gra_wr) begin
            s_d.gra = wdata;
        end else if (tick && cap && s_q.ctrl.cap_a) begin
            s_d.gra = s_q.cnt;
        end

        if (grb_wr) begin
            s_d.grb = wdata;
        end else if (tick && cap && s_q.ctrl.cap_b) begin
            s_d.grb = s_q.cnt;
        end

        if (ctrl_wr) begin
            s_d.ctrl = ch_ctrl_t'(wdata[CTRL_W-1:0]);
        end

        // PWM: fall wins over rise
        if (!s_q.ctrl.pwm_en) begin
            s_d.pwm = 1'b0;
        end else if (hit_b) begin
            s_d.pwm = 1'b0;
        end else if (hit_a) begin
            s_d.pwm = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.gra  <= '1;
            s_q.grb  <= '1;
            s_q.ctrl <= '0;
            s_q.pwm  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign src_clr = own_clr;
    assign cnt     = s_q.cnt;
    assign gra     = s_q.gra;
    assign grb     = s_q.grb;
    assign ctrl    = s_q.ctrl;
    assign pwm     = s_q.pwm;

endmodule

// File: rtl/sptmr_link.sv
module sptmr_link #(
    parameter int NCH = 3
) (
    input  logic [NCH-1:0] sync_mask,
    input  logic [NCH-1:0] src_clr,
    input  logic [NCH-1:0] own_load,
    output logic [NCH-1:0] cnt_load,
    output logic           sync_clr
);

    logic group_load;

    always_comb begin
        group_load = |(own_load & sync_mask);
        sync_clr   = |(src_clr & sync_mask);
        for (int i = 0; i < NCH; i++) begin
            cnt_load[i] = own_load[i] || (sync_mask[i] && group_load);
        end
    end

endmodule

// File: rtl/sync_pwm_timer.sv
module sync_pwm_timer
    import sptmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16,
    localparam int NREG = NCH * 4 + 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cnt_en,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    input  logic           bus_we,
    output logic [CW-1:0]  bus_rdata,
    input  logic [NCH-1:0] cap_in,
    output logic [NCH-1:0] pwm_out
);

    localparam logic [AW-1:0] A_SYNC  = AW'(NCH * 4);
    localparam logic [AW-1:0] A_START = AW'(NCH * 4 + 1);

    typedef struct packed {
        logic [NCH-1:0] sync;
        logic [NCH-1:0] start;
    } shared_st_t;

    shared_st_t sh_q, sh_d;

    logic [NCH-1:0]          sync_mask, start_mask;
    logic [NCH-1:0]          own_load, cnt_load, gra_wr, grb_wr, ctrl_wr, src_clr;
    logic                    sync_clr;
    logic [NCH-1:0][CW-1:0]  cnt_v, gra_v, grb_v;
    ch_ctrl_t [NCH-1:0]      ctrl_v;

    always_comb begin
        sh_d = sh_q;
        if (bus_we && bus_addr == A_SYNC)  sh_d.sync  = bus_wdata[NCH-1:0];
        if (bus_we && bus_addr == A_START) sh_d.start = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sync_mask  = sh_q.sync;
    assign start_mask = sh_q.start;

    sptmr_link #(.NCH(NCH)) u_link (
        .sync_mask (sync_mask),
        .src_clr   (src_clr),
        .own_load  (own_load),
        .cnt_load  (cnt_load),
        .sync_clr  (sync_clr)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign own_load[i] = bus_we && (bus_addr == AW'(i * 4));
        assign gra_wr[i]   = bus_we && (bus_addr == AW'(i * 4 + 1));
        assign grb_wr[i]   = bus_we && (bus_addr == AW'(i * 4 + 2));
        assign ctrl_wr[i]  = bus_we && (bus_addr == AW'(i * 4 + 3));

        sptmr_chan #(.CW(CW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (cnt_en && start_mask[i]),
            .cnt_load    (cnt_load[i]),
            .gra_wr      (gra_wr[i]),
            .grb_wr      (grb_wr[i]),
            .ctrl_wr     (ctrl_wr[i]),
            .wdata       (bus_wdata),
            .cap         (cap_in[i]),
            .sync_member (sync_mask[i]),
            .sync_clr    (sync_clr),
            .src_clr     (src_clr[i]),
            .cnt         (cnt_v[i]),
            .gra         (gra_v[i]),
            .grb         (grb_v[i]),
            .ctrl        (ctrl_v[i]),
            .pwm         (pwm_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(i * 4))     bus_rdata = cnt_v[i];
            if (bus_addr == AW'(i * 4 + 1)) bus_rdata = gra_v[i];
            if (bus_addr == AW'(i * 4 + 2)) bus_rdata = grb_v[i];
            if (bus_addr == AW'(i * 4 + 3)) bus_rdata = CW'(ctrl_v[i]);
        end
        if (bus_addr == A_SYNC)  bus_rdata = CW'(sh_q.sync);
        if (bus_addr == A_START) bus_rdata = CW'(sh_q.start);
    end

endmodule

// File: rtl/sptmr_chk.sv
module sptmr_chk
    import sptmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int AW  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [AW-1:0]          bus_addr,
    input logic [CW-1:0]          bus_wdata,
    input logic [NCH-1:0]         pwm_out,
    input logic [NCH-1:0][CW-1:0] cnt_v,
    input ch_ctrl_t [NCH-1:0]     ctrl_v,
    input logic [NCH-1:0]         sync_mask,
    input logic [NCH-1:0]         start_mask
);

    for (genvar i = 0; i < NCH; i++) begin : g_i
        p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_we && !start_mask[i]) |=> $stable(cnt_v[i]));

        p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_we |=> (cnt_v[i] == $past(cnt_v[i]) ||
                         cnt_v[i] == $past(cnt_v[i]) + CW'(1) ||
                         cnt_v[i] == '0));

        p_pwm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_v[i].pwm_en |=> !pwm_out[i]);

        p_nosync_noclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_we && !sync_mask[i] && ctrl_v[i].sel == CLR_SYNC &&
             cnt_v[i] != '0 && cnt_v[i] != '1) |=> (cnt_v[i] != '0));

        for (genvar j = 0; j < NCH; j++) begin : g_j
            p_group_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == AW'(j * 4) && sync_mask[j] && sync_mask[i])
                |=> (cnt_v[i] == $past(bus_wdata)));
        end
    end

endmodule

bind sync_pwm_timer sptmr_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pwm_out    (pwm_out),
    .cnt_v      (cnt_v),
    .ctrl_v     (ctrl_v),
    .sync_mask  (sync_mask),
    .start_mask (start_mask)
);

// File: tb/test_sync_pwm_timer.sv
`timescale 1ns/1ps
module test_sync_pwm_timer;

    localparam int NCH = 3;
    localparam int CW  = 16;
    localparam int AW  = 4;
    localparam int A_SYNC  = 12;
    localparam int A_START = 13;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cnt_en = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [CW-1:0]  bus_wdata = '0;
    logic           bus_we = 1'b0;
    logic [CW-1:0]  bus_rdata;
    logic [NCH-1:0] cap_in = '0;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_pwm_timer #(.NCH(NCH), .CW(CW)) i_sync_pwm_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .pwm_out   (pwm_out)
    );

    function automatic int a_cnt(int ch);  return ch * 4;     endfunction
    function automatic int a_gra(int ch);  return ch * 4 + 1; endfunction
    function automatic int a_grb(int ch);  return ch * 4 + 2; endfunction
    function automatic int a_ctrl(int ch); return ch * 4 + 3; endfunction

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1'b0; bus_we = 1'b0; cap_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = CW'(d); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        bus_addr = AW'(a);
        #1;
        check(req, bus_rdata, CW'(exp));
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cnt_en = 1'b1;
            @(negedge clk); cnt_en = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        for (int ch = 0; ch < NCH; ch++) begin
            rd_chk("R1 cnt", a_cnt(ch), 0);
            rd_chk("R1 gra", a_gra(ch), 16'hFFFF);
            rd_chk("R1 grb", a_grb(ch), 16'hFFFF);
            rd_chk("R1 ctrl", a_ctrl(ch), 0);
        end
        rd_chk("R1 sync", A_SYNC, 0);
        rd_chk("R1 start", A_START, 0);
        check("R1 pwm", CW'(pwm_out), 0);

        // R10: register map readback
        wr(a_gra(2), 16'hA5A5);  rd_chk("R10 gra2", a_gra(2), 16'hA5A5);
        wr(a_grb(0), 16'h0F0F);  rd_chk("R10 grb0", a_grb(0), 16'h0F0F);
        wr(a_ctrl(1), 16'hFFFF); rd_chk("R10 ctrl1", a_ctrl(1), 16'h001F);
        wr(A_SYNC, 16'hFFFF);    rd_chk("R10 sync", A_SYNC, 7);

        // R2: count, hold, wrap
        do_reset();
        wr(A_START, 1);
        tick_n(10);
        rd_chk("R2 run ch0", a_cnt(0), 10);
        rd_chk("R2 stopped ch1", a_cnt(1), 0);
        repeat (5) @(negedge clk);
        rd_chk("R2 hold no enable", a_cnt(0), 10);
        wr(a_cnt(0), 16'hFFFE);
        tick_n(3);
        rd_chk("R2 wrap", a_cnt(0), 1);

        // R3: synchronous preset
        do_reset();
        wr(A_SYNC, 3);
        wr(a_cnt(1), 16'h0100);
        rd_chk("R3 ch0 loaded", a_cnt(0), 16'h0100);
        rd_chk("R3 ch1 loaded", a_cnt(1), 16'h0100);
        rd_chk("R3 ch2 untouched", a_cnt(2), 0);
        wr(a_cnt(2), 16'h0055);
        rd_chk("R3 ch2 own", a_cnt(2), 16'h0055);
        rd_chk("R3 ch0 not from ch2", a_cnt(0), 16'h0100);
        wr(a_cnt(0), 16'h0200);
        rd_chk("R3 ch1 from ch0", a_cnt(1), 16'h0200);

        // R4 / R9: compare-match clear sweep
        do_reset();
        wr(a_ctrl(2), 1); wr(a_gra(2), 4);
        wr(a_gra(1), 3); wr(a_grb(1), 2);
        for (int g = 0; g < 8; g++) begin
            wr(A_START, 0);
            wr(a_grb(0), g); wr(a_ctrl(0), 2);
            for (int ch = 0; ch < NCH; ch++) wr(a_cnt(ch), 0);
            wr(A_START, 7);
            for (int n = 1; n <= 20; n++) begin
                tick_n(1);
                rd_chk("R4 clear on B", a_cnt(0), n % (g + 1));
                rd_chk("R9 no clear", a_cnt(1), n);
                rd_chk("R4 clear on A", a_cnt(2), n % 5);
            end
        end

        // R6: synchronous clear sweep
        do_reset();
        wr(A_SYNC, 7);
        wr(a_ctrl(1), 3); wr(a_ctrl(2), 3);
        for (int g = 1; g < 7; g++) begin
            wr(A_START, 0);
            wr(a_grb(0), g); wr(a_ctrl(0), 2);
            wr(a_cnt(0), 0);
            wr(A_START, 7);
            for (int n = 1; n <= 16; n++) begin
                tick_n(1);
                for (int ch = 0; ch < NCH; ch++)
                    rd_chk("R6 sync clear", a_cnt(ch), n % (g + 1));
            end
        end
        wr(A_START, 0);
        wr(A_SYNC, 1);
        wr(a_grb(0), 4);
        wr(a_cnt(1), 0);
        wr(a_cnt(0), 0);
        rd_chk("R6 unsynced ignores other write", a_cnt(2), 16 % 7);
        wr(A_START, 7);
        tick_n(12);
        rd_chk("R6 master", a_cnt(0), 2);
        rd_chk("R6 unsynced ignores sync clear", a_cnt(1), 12);

        // R8: PWM waveform
        do_reset();
        wr(a_gra(0), 3); wr(a_grb(0), 9); wr(a_ctrl(0), 16'h12);
        wr(a_gra(1), 6); wr(a_grb(1), 9); wr(a_ctrl(1), 16'h13);
        wr(a_gra(2), 5); wr(a_grb(2), 5); wr(a_ctrl(2), 16'h13);
        wr(A_SYNC, 7);
        wr(A_START, 7);
        begin
            logic p0, p1;
            p0 = 1'b0; p1 = 1'b0;
            for (int k = 0; k < 30; k++) begin
                int c;
                c = k % 10;
                if (c == 9) p0 = 1'b0; else if (c == 3) p0 = 1'b1;
                if (c == 9) p1 = 1'b0; else if (c == 6) p1 = 1'b1;
                tick_n(1);
                check("R8 pwm ch0", CW'(pwm_out[0]), CW'(p0));
                check("R8 pwm ch1", CW'(pwm_out[1]), CW'(p1));
                check("R8 pwm both match low", CW'(pwm_out[2]), 0);
                rd_chk("R6 phase counter ch2", a_cnt(2), (k + 1) % 10);
            end
        end

        // R5: input capture
        do_reset();
        wr(a_ctrl(0), 16'h05);
        wr(a_ctrl(1), 16'h08);
        wr(A_START, 3);
        tick_n(7);
        @(negedge clk); cap_in = 3'b011; cnt_en = 1'b1;
        @(negedge clk); cap_in = '0; cnt_en = 1'b0;
        rd_chk("R5 capture A", a_gra(0), 7);
        rd_chk("R5 capture clears", a_cnt(0), 0);
        rd_chk("R5 capture B", a_grb(1), 7);
        rd_chk("R5 capture no clear", a_cnt(1), 8);
        tick_n(3);
        @(negedge clk); cap_in = 3'b010;
        @(negedge clk); cap_in = '0;
        rd_chk("R5 no capture when idle", a_grb(1), 7);
        rd_chk("R5 counter after capture", a_cnt(0), 3);

        // R7: write priority over clear and count
        do_reset();
        wr(a_grb(0), 5); wr(a_ctrl(0), 2);
        wr(A_START, 1);
        tick_n(5);
        rd_chk("R7 at match", a_cnt(0), 5);
        @(negedge clk);
        cnt_en = 1'b1; bus_we = 1'b1; bus_addr = AW'(a_cnt(0)); bus_wdata = 16'h0077;
        @(negedge clk);
        cnt_en = 1'b0; bus_we = 1'b0;
        rd_chk("R7 write wins", a_cnt(0), 16'h0077);
        tick_n(1);
        rd_chk("R7 counts after write", a_cnt(0), 16'h0078);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule